// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel. Software reaches it through a byte-wide interface that has two ports. The data port carries count bytes. The control port carries mode words and commands. Counting advances only on clock cycles where the `tick` enable is high. The `gate` input either pauses counting or, in the triggered mode, starts a timeout. The `out` pin produces the waveform of the selected mode: a single timeout edge, a triggered pulse, a one-tick strobe at a fixed rate, or a square wave.

A control word selects one of four modes and one of three byte orders. A control word can instead be a command that freezes the current count for reading, or that captures a status byte. A read returns the byte shown on `rdata`. Asserting `rd_en` for one cycle consumes that byte and advances the read sequence. A reload value of zero stands for 65536 counts.

Top module: `pit_chan`

## Requirements
- R1: After reset, `out` is low and a data read shows 0x00. A status capture then reads 0x30: mode 0, two-byte access, no count loaded.
- R2: Control words are written with `addr`=1. A word with bits 7:6 = 11 captures status. Otherwise, bits 5:4 = 00 latch the count. Otherwise, the word programs the channel with access = bits 5:4 and mode = bits 3:1. A programming word whose mode field is 100–111 is ignored and leaves all state unchanged.
- R3: Access code 10 transfers only the low byte, and the high byte of the count is zero. Code 01 transfers only the high byte, and the low byte is zero. Code 11 transfers the low byte first and then the high byte, for both writes and reads. Single-byte reads repeat the same byte.
- R4: A count latch freezes the current count. Reads return the frozen value until all of its bytes have been read. Live reads then resume.
- R5: The status byte is {out, loaded, access[1:0], mode[2:0], 0}. `loaded` is set when a count is fully written. It is cleared by a programming word. In modes 0 and 1 it is also cleared when the count expires.
- R6: Mode 0: completing a count write N drives `out` low. The first tick loads the count, and N further ticks bring it to zero. At that point `out` goes high and stays high until a new count is written.
- R7: Mode 1: `out` idles high. A rising `gate` edge arms a trigger. The next tick loads the count and drives `out` low. After N more ticks `out` returns high, regardless of `gate`. Each further rising edge retriggers the count.
- R8: Mode 2, with N ≥ 2: after the count loads, `out` is low for exactly one tick out of every N ticks. The counter reloads on the tick after it reaches 1.
- R9: Mode 3, with N ≥ 2: `out` toggles each half period. The counter steps by two, so a read only ever shows even values. For odd N the high half lasts (N+1)/2 ticks and the low half lasts (N-1)/2 ticks. For even N each half lasts N/2 ticks.
- R10: In modes 0, 2 and 3, ticks that arrive while `gate` is low leave the count and `out` unchanged.
- R11: A reload value of 0 counts as 65536.
- R12: A programming word resets the byte pointers for both writes and reads. It drives `out` to the idle level of the new mode: low for mode 0, high for the other modes.
- R13: `out` changes only in a cycle where `tick` or a register write is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one count per high cycle |
| gate | input | 1 | Gate: enables counting, or triggers in mode 1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = data port, 1 = control port |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Consumes the byte shown on rdata |
| rdata | output | 8 | Byte shown for the next data-port read |
| out | output | 1 | Timer output waveform |

## Verification
The channel has no parameters, so the bench builds it in its only configuration: a full 16-bit counter. With that configuration the zero-means-65536 reload can be run to the real terminal count, in about 65 thousand tick cycles. The vector table sweeps reload values in modes 2 and 3, including the minimum of 2 and several odd values. This measures the high and low intervals after the first period has passed. The directed tests cover the byte-order variants, a latch held across counting, gate pausing, retriggering and pointer reset.

// File: rtl/pit_chan.sv
module pit_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       gate,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       out
);
  logic [2:0]  mode;
  logic [1:0]  acc;
  logic [15:0] rv, cnt, lat;
  logic [7:0]  lo_buf, stat;
  logic        wr_hi, rd_hi, lat_v, stat_v, pend, run, loaded, gate_q, trig, out_q;

  wire         wr_ctl   = wr_en & addr;
  wire         wr_dat   = wr_en & ~addr;
  wire         cmd_stat = wr_ctl & (wdata[7:6] == 2'b11);
  wire         cmd_lat  = wr_ctl & ~cmd_stat & (wdata[5:4] == 2'b00);
  wire         cmd_prog = wr_ctl & ~cmd_stat & (wdata[5:4] != 2'b00) & ~wdata[3];
  wire         wr_done  = wr_dat & ((acc != 2'b11) | wr_hi);
  wire [15:0]  new_rv   = (acc == 2'b01) ? {wdata, 8'h00} :
                          (acc == 2'b10) ? {8'h00, wdata} : {wdata, lo_buf};
  wire [15:0]  hi_ld    = rv + {15'd0, rv[0]};
  wire [15:0]  lo_ld    = rv - {15'd0, rv[0]};
  wire [15:0]  src      = lat_v ? lat : cnt;
  wire         rd_msb   = (acc == 2'b01) | ((acc == 2'b11) & rd_hi);
  wire         rd_last  = (acc != 2'b11) | rd_hi;
  wire [7:0]   status   = {out_q, loaded, acc, mode, 1'b0};
  wire         counting = run & (gate | (mode == 3'd1));

  assign rdata = stat_v ? stat : (rd_msb ? src[15:8] : src[7:0]);
  assign out   = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 3'd0;   acc <= 2'b11;
      rv <= '0;       cnt <= '0;     lat <= '0;
      lo_buf <= '0;   stat <= '0;
      wr_hi <= 1'b0;  rd_hi <= 1'b0; lat_v <= 1'b0; stat_v <= 1'b0;
      pend <= 1'b0;   run <= 1'b0;   loaded <= 1'b0;
      gate_q <= 1'b0; trig <= 1'b0;  out_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cmd_prog) begin
        mode   <= wdata[3:1];
        acc    <= wdata[5:4];
        wr_hi  <= 1'b0;
        rd_hi  <= 1'b0;
        lat_v  <= 1'b0;
        stat_v <= 1'b0;
        pend   <= 1'b0;
        run    <= 1'b0;
        loaded <= 1'b0;
        trig   <= 1'b0;
        out_q  <= (wdata[3:1] != 3'd0);
      end else begin
        if (wr_dat) begin
          if (wr_done) begin
            rv     <= new_rv;
            wr_hi  <= 1'b0;
            loaded <= 1'b1;
            pend   <= (mode != 3'd1);
            if (mode == 3'd0) begin
              out_q <= 1'b0;
              run   <= 1'b0;
            end
          end else begin
            lo_buf <= wdata;
            wr_hi  <= 1'b1;
          end
        end
        if (cmd_lat & ~lat_v) begin
          lat   <= cnt;
          lat_v <= 1'b1;
        end
        if (cmd_stat & ~stat_v) begin
          stat   <= status;
          stat_v <= 1'b1;
        end
        if (rd_en) begin
          if (stat_v) stat_v <= 1'b0;
          else begin
            rd_hi <= (acc == 2'b11) & ~rd_hi;
            if (rd_last) lat_v <= 1'b0;
          end
        end
        if ((mode == 3'd1) & gate & ~gate_q) trig <= 1'b1;
        if (tick) begin
          if (pend) begin
            cnt  <= (mode == 3'd3) ? hi_ld : rv;
            run  <= 1'b1;
            pend <= 1'b0;
            if (mode != 3'd0) out_q <= 1'b1;
          end else if ((mode == 3'd1) & trig) begin
            cnt    <= rv;
            out_q  <= 1'b0;
            run    <= 1'b1;
            trig   <= 1'b0;
            loaded <= 1'b1;
          end else if (counting) begin
            case (mode)
              3'd2: begin
                if (cnt == 16'd1) begin
                  cnt   <= rv;
                  out_q <= 1'b1;
                end else begin
                  cnt <= cnt - 16'd1;
                  if (cnt == 16'd2) out_q <= 1'b0;
                end
              end
              3'd3: begin
                if (cnt == 16'd2) begin
                  out_q <= ~out_q;
                  cnt   <= out_q ? lo_ld : hi_ld;
                end else begin
                  cnt <= cnt - 16'd2;
                end
              end
              default: begin
                cnt <= cnt - 16'd1;
                if (cnt == 16'd1) begin
                  out_q  <= 1'b1;
                  loaded <= 1'b0;
                end
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/pit_chan_chk.sv
module pit_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       gate,
  input logic       wr_en,
  input logic       addr,
  input logic [7:3] wd,
  input logic       out,
  input logic [2:0] mode,
  input logic       cnt0,
  input logic       run
);
  assert_out_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(out));

  assert_bad_mode_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && wd[7:6] != 2'b11 && wd[5:4] != 2'b00 && wd[3]) |=> $stable(mode));

  assert_timeout_holds_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && out && !wr_en) |=> out);

  assert_strobe_one_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !out && tick && gate && !wr_en) |=> out);

  assert_square_count_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && run) |-> !cnt0);
endmodule

bind pit_chan pit_chan_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .tick (tick),
  .gate (gate),
  .wr_en(wr_en),
  .addr (addr),
  .wd   (wdata[7:3]),
  .out  (out),
  .mode (mode),
  .cnt0 (cnt[0]),
  .run  (run)
);

// File: tb/pit_chan_bench.sv
`timescale 1ns/1ps
module pit_chan_bench;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate = 1'b1;
  logic       wr_en = 1'b0, addr = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       out;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pit_chan u_pit_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .out(out)
  );

  // {mode, reload, high ticks, low ticks}
  localparam logic [31:0] VEC [8] = '{
    32'h02030201, 32'h020A0901, 32'h02020101, 32'h03040202,
    32'h03050302, 32'h03070403, 32'h03020101, 32'h03090504
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    v = rdata;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out after reset", out, 0);
    chk("R1 data after reset", rdata, 8'h00);
    wr(1, 8'hC0);
    rd(b); chk("R1 R5 reset status", b, 8'h30);

    for (int i = 0; i < 8; i++) begin
      int h, l, g;
      wr(1, {2'b00, 2'b11, VEC[i][26:24], 1'b0});
      wr(0, VEC[i][23:16]);
      wr(0, 8'h00);
      g = 0;
      while (out !== 1'b0 && g < 100) begin ticks(1); g++; end
      l = 0;
      do begin ticks(1); l++; end while (out === 1'b0 && l < 100);
      h = 0;
      do begin ticks(1); h++; end while (out === 1'b1 && h < 100);
      chk(VEC[i][31:24] == 8'd2 ? "R8 high ticks" : "R9 high ticks", 16'(h), {8'h00, VEC[i][15:8]});
      chk(VEC[i][31:24] == 8'd2 ? "R8 low ticks" : "R9 low ticks", 16'(l), {8'h00, VEC[i][7:0]});
    end

    // R6 software timeout
    wr(1, 8'h30); wr(0, 8'h05); wr(0, 8'h00);
    chk("R6 low on write", out, 0);
    wr(1, 8'hC0); rd(b); chk("R5 loaded status", b, 8'h70);
    ticks(5); chk("R6 still low", out, 0);
    ticks(1); chk("R6 high at zero", out, 1);
    wr(1, 8'hC0); rd(b); chk("R5 expired status", b, 8'hB0);

    // R10 gate pause
    wr(1, 8'h30); wr(0, 8'h03); wr(0, 8'h00);
    ticks(1);
    gate = 1'b0;
    ticks(5); chk("R10 out held", out, 0);
    rd(b); chk("R10 count held", b, 8'h03);
    rd(b);
    gate = 1'b1;
    ticks(2); chk("R10 resumes", out, 0);
    ticks(1); chk("R10 expires", out, 1);

    // R4 latch
    wr(1, 8'h30); wr(0, 8'h34); wr(0, 8'h12);
    ticks(3);
    wr(1, 8'h00);
    ticks(3);
    rd(b); chk("R4 latched lsb", b, 8'h32);
    rd(b); chk("R4 latched msb", b, 8'h12);
    rd(b); chk("R4 live lsb", b, 8'h2F);
    rd(b); chk("R4 live msb", b, 8'h12);

    // R3 access types
    wr(1, 8'h20); wr(0, 8'hAB); ticks(1);
    rd(b); chk("R3 lsb-only", b, 8'hAB);
    rd(b); chk("R3 lsb-only repeat", b, 8'hAB);
    wr(1, 8'h10); wr(0, 8'h07); ticks(1);
    rd(b); chk("R3 msb-only", b, 8'h07);
    rd(b); chk("R3 msb-only repeat", b, 8'h07);
    wr(1, 8'hC0); rd(b); chk("R3 R5 msb-only status", b, 8'h50);

    // R2 unsupported mode ignored
    wr(1, 8'h38);
    chk("R2 out unchanged", out, 0);
    wr(1, 8'hC0); rd(b); chk("R2 status unchanged", b, 8'h50);

    // R12 pointer reset and idle level
    wr(1, 8'h30); wr(0, 8'h55);
    wr(1, 8'h34);
    chk("R12 idle high", out, 1);
    wr(1, 8'hC0); rd(b); chk("R12 R5 status after program", b, 8'hB4);
    wr(0, 8'h04); wr(0, 8'h00);
    ticks(3); chk("R12 high before strobe", out, 1);
    ticks(1); chk("R12 strobe low", out, 0);

    // R13 no tick, no change
    repeat (10) @(negedge clk);
    chk("R13 held without tick", out, 0);
    ticks(1); chk("R8 strobe ends", out, 1);

    // R7 triggered one-shot
    gate = 1'b0;
    wr(1, 8'h32);
    chk("R7 idle high", out, 1);
    wr(0, 8'h03); wr(0, 8'h00);
    ticks(4); chk("R7 no trigger", out, 1);
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
    ticks(1); chk("R7 triggered low", out, 0);
    ticks(2); chk("R7 still low", out, 0);
    ticks(1); chk("R7 expires", out, 1);
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
    ticks(1); chk("R7 retrigger", out, 0);

    // R9 even reads
    wr(1, 8'h36); wr(0, 8'h07); wr(0, 8'h00);
    ticks(1);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] lo;
      ticks(1);
      rd(lo); rd(b);
      chk("R9 even count", {15'd0, lo[0]}, 0);
    end

    // R11 zero reload
    wr(1, 8'h30); wr(0, 8'h00); wr(0, 8'h00);
    ticks(65536); chk("R11 still low", out, 0);
    ticks(1); chk("R11 expires after 65536", out, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule